// File: doc/BRIEF.md
# CSI-2 Long-Packet Payload Extractor

This block sits behind a four-lane camera serial receiver whose lanes are already byte- and lane-aligned. It consumes one 32-bit word per byte clock, with lane 0 in the least significant byte. The first valid word of every high-speed burst is taken as the packet header. If that header announces a long packet of the selected data type (RAW10, code 0x2B, by default), the payload words that follow are passed through unchanged. A per-lane byte enable marks exactly as many bytes as the header's word count. The header, the two-byte trailing checksum and any filler up to the end of the burst are never marked valid. Short packets and long packets of any other type are swallowed.

The data type, virtual channel and payload length of the last accepted packet are held on plain side outputs, so a downstream unpacker can size its line. Both data paths use valid/ready. `in_ready` follows `out_ready` only while payload is being forwarded. In every other state the block accepts input freely, because it is discarding or decoding it. A stalled upstream must keep `in_valid` high and the word stable, since a low `in_valid` means the burst has ended. That ends the current packet and re-arms the header search.

Top module: `csi_payload_extractor`

## Requirements
- R1: During and straight after reset, `out_valid` is 0, `out_byte_en` is 0, `in_ready` is 1, and `pkt_dtype`, `pkt_vc` and `pkt_len` are 0.
- R2: The first word with `in_valid` high after reset or after a cycle with `in_valid` low is the header. Its fields are: byte 0 bits 5:0 the data type, byte 0 bits 7:6 the virtual channel, byte 1 the word-count low byte, byte 2 the word-count high byte, and byte 3 a check byte that is ignored. The header word itself never raises `out_valid`.
- R3: A header whose data type differs from MATCH_DT (default 0x2B) causes no `out_valid` for the rest of its burst, and leaves `pkt_dtype`, `pkt_vc` and `pkt_len` unchanged.
- R4: Data types 0x00 to 0x0F are short packets. Their bytes 1 and 2 are not a length. They produce no output and update no side output.
- R5: A forwarded payload word appears on `out_data` unchanged, in the same cycle and in the same lane positions as on `in_data`.
- R6: In the k-th accepted payload word (k from 0), lane i is enabled exactly when 4k+i is less than the word count. `out_valid` is high only when at least one lane is enabled. The checksum bytes after the payload are never enabled, even when they share a word with the last payload byte.
- R7: On a matching long-packet header, `pkt_dtype`, `pkt_vc` and `pkt_len` load its fields from the following cycle on. They hold until the next matching header.
- R8: A low `in_valid` at any point, including mid-payload, ends the packet. The next valid word is decoded as a new header.
- R9: While payload is being forwarded, `in_ready` equals `out_ready`. A word offered with `out_ready` low is not counted and is offered again. In all other states `in_ready` is 1 regardless of `out_ready`.
- R10: A matching long packet with word count 0 updates the side outputs, with `pkt_len` 0, and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lane-aligned word valid; low between bursts |
| in_ready | output | 1 | Block accepts the input word |
| in_data | input | 32 | Four lane bytes, lane 0 in bits 7:0 |
| out_valid | output | 1 | At least one payload byte valid |
| out_ready | input | 1 | Downstream accepts the payload word |
| out_data | output | 32 | Payload word, lanes as received |
| out_byte_en | output | 4 | Per-lane payload byte enable |
| pkt_dtype | output | 6 | Data type of the last accepted packet |
| pkt_vc | output | 2 | Virtual channel of the last accepted packet |
| pkt_len | output | 16 | Payload byte count of the last accepted packet |

## Verification
Three things can land in the same cycle and are judged together. The last payload bytes and the first checksum bytes can share one word, as with word counts of 5 and 7. Back-pressure can hold that same final word, or a middle word. A burst can also end on the cycle after the last word, and the next header can follow one idle cycle later. The bench drives these patterns through a behavioural model that tracks the remaining byte budget. On every clock it compares the ready, valid, per-lane enable, data and side outputs against the model, so a stalled word that is wrongly counted, or a checksum byte that leaks, shows up in the cycle it happens.

// File: rtl/csi_strip_pkg.sv
package csi_strip_pkg;

  // Parser phase within one high-speed burst
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,  // next valid word is a header
    ST_PASS  = 2'd1,  // forwarding payload against the byte budget
    ST_DRAIN = 2'd2   // discard until the burst ends
  } strip_state_e;

  typedef struct packed {
    logic [1:0]  vc;
    logic [5:0]  dt;
    logic [15:0] wc;
  } hdr_fields_t;

  localparam logic [5:0] LONG_DT_MIN = 6'h10;

  function automatic logic dt_is_long(input logic [5:0] dt);
    return dt >= LONG_DT_MIN;
  endfunction

endpackage

// File: rtl/csi_hdr_decode.sv
module csi_hdr_decode
  import csi_strip_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [5:0]  MATCH_DT = 6'h2B
) (
  input  logic [3*BYTE_W-1:0] hdr_bytes,  // header bytes 0..2, byte 0 lowest
  output hdr_fields_t         fields,
  output logic                is_long,
  output logic                is_match
);
  localparam int HB = 3;

  logic [BYTE_W-1:0] hb [HB];

  for (genvar g = 0; g < HB; g++) begin : g_split
    assign hb[g] = hdr_bytes[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    fields.dt = hb[0][5:0];
    fields.vc = hb[0][7:6];
    // word count arrives low byte first
    fields.wc = {hb[2], hb[1]};
  end

  assign is_long  = dt_is_long(fields.dt);
  assign is_match = is_long && (fields.dt == MATCH_DT);

endmodule

// File: rtl/csi_byte_budget.sv
module csi_byte_budget #(
  parameter int LANES = 4,
  parameter int WC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WC_W-1:0]  load_val,
  input  logic             consume,
  output logic [LANES-1:0] lane_en,
  output logic             last_beat,
  output logic             nonzero
);
  localparam logic [WC_W-1:0] STEP = WC_W'(LANES);

  logic [WC_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        rem_q <= '0;
    else if (load)     rem_q <= load_val;
    else if (consume)  rem_q <= last_beat ? '0 : rem_q - STEP;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = rem_q > WC_W'(i);
  end

  assign last_beat = rem_q <= STEP;
  assign nonzero   = rem_q != '0;

  // R6: the budget only ever shrinks when a word is taken
  p_budget_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !load && nonzero) |=> (rem_q < $past(rem_q)));

  // R9: a stalled word leaves the budget untouched
  p_budget_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume && !load) |=> $stable(rem_q));

endmodule

// File: rtl/csi_strip_ctrl.sv
module csi_strip_ctrl
  import csi_strip_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         hdr_long,
  input  logic         hdr_match,
  input  logic         hdr_wc_zero,
  input  logic         beat,
  input  logic         budget_last,
  output strip_state_e state
);
  strip_state_e nxt;

  always_comb begin
    nxt = state;
    if (!in_valid) begin
      nxt = ST_HUNT;
    end else begin
      unique case (state)
        ST_HUNT:  nxt = (hdr_match && !hdr_wc_zero) ? ST_PASS : ST_DRAIN;
        ST_PASS:  if (beat && budget_last) nxt = ST_DRAIN;
        ST_DRAIN: nxt = ST_DRAIN;
        default:  nxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_HUNT;
    else        state <= nxt;
  end

  // R8: end of burst always re-arms the header search
  p_drop_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (state == ST_HUNT));

  // R4: a short-packet header never opens the payload path
  p_short_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && in_valid && !hdr_long) |=> (state == ST_DRAIN));

endmodule

// File: rtl/csi_payload_extractor.sv
module csi_payload_extractor
  import csi_strip_pkg::*;
#(
  parameter int         LANES    = 4,
  parameter int         BYTE_W   = 8,
  parameter int         WC_W     = 16,
  parameter logic [5:0] MATCH_DT = 6'h2B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*BYTE_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*BYTE_W-1:0] out_data,
  output logic [LANES-1:0]        out_byte_en,
  output logic [5:0]              pkt_dtype,
  output logic [1:0]              pkt_vc,
  output logic [WC_W-1:0]         pkt_len
);
  localparam int HDR_BITS = 3 * BYTE_W;

  strip_state_e state;
  hdr_fields_t  hdr;
  logic         hdr_long, hdr_match, hdr_take, take_match;
  logic         in_pass, beat;
  logic [LANES-1:0] lane_en;
  logic         budget_last, budget_nz;

  csi_hdr_decode #(.BYTE_W(BYTE_W), .MATCH_DT(MATCH_DT)) u_dec (
    .hdr_bytes (in_data[HDR_BITS-1:0]),
    .fields    (hdr),
    .is_long   (hdr_long),
    .is_match  (hdr_match)
  );

  assign in_pass    = (state == ST_PASS);
  assign hdr_take   = (state == ST_HUNT) && in_valid;
  assign take_match = hdr_take && hdr_match;
  assign beat       = in_pass && in_valid && out_ready;

  csi_byte_budget #(.LANES(LANES), .WC_W(WC_W)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_match),
    .load_val  (WC_W'(hdr.wc)),
    .consume   (beat),
    .lane_en   (lane_en),
    .last_beat (budget_last),
    .nonzero   (budget_nz)
  );

  csi_strip_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .hdr_long    (hdr_long),
    .hdr_match   (hdr_match),
    .hdr_wc_zero (hdr.wc == '0),
    .beat        (beat),
    .budget_last (budget_last),
    .state       (state)
  );

  // back-pressure reaches upstream only while payload is flowing (R9)
  assign in_ready    = in_pass ? out_ready : 1'b1;
  assign out_valid   = in_pass && in_valid;
  assign out_byte_en = out_valid ? lane_en : '0;
  assign out_data    = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_dtype <= '0;
      pkt_vc    <= '0;
      pkt_len   <= '0;
    end else if (take_match) begin
      pkt_dtype <= hdr.dt;
      pkt_vc    <= hdr.vc;
      pkt_len   <= WC_W'(hdr.wc);
    end
  end

  // R2: nothing leaves while a header is being decoded
  p_hdr_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |-> !out_valid);

  // R6: enables are a contiguous run starting at lane 0
  p_en_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_byte_en[0] && (((out_byte_en + 1'b1) & out_byte_en) == '0)));

  // R6: forwarding is only possible with budget left
  p_pass_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_pass |-> budget_nz);

  // R9: outside payload the block never stalls its source
  p_ready_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_pass |-> in_ready);

  // R7: side outputs change only after an accepted header
  p_meta_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_match |=> ($stable(pkt_len) && $stable(pkt_dtype) && $stable(pkt_vc)));

endmodule

// File: tb/tb_csi_payload_extractor.sv
module tb_csi_payload_extractor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_data, out_data;
  logic [3:0]  out_byte_en;
  logic [5:0]  pkt_dtype;
  logic [1:0]  pkt_vc;
  logic [15:0] pkt_len;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  // model state: 0 hunt, 1 forwarding, 2 discarding
  int          m_mode = 0;
  int          m_rem  = 0;
  logic [5:0]  m_dt   = '0;
  logic [1:0]  m_vc   = '0;
  logic [15:0] m_len  = '0;

  always #5 clk = ~clk;

  csi_payload_extractor dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_byte_en(out_byte_en),
    .pkt_dtype(pkt_dtype), .pkt_vc(pkt_vc), .pkt_len(pkt_len)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input logic [1:0] vc, input logic [5:0] dt,
                                         input logic [15:0] wc);
    return {8'h5E, wc[15:8], wc[7:0], vc, dt};
  endfunction

  // one clock: drive, compare against model, advance model
  task automatic step(input logic v, input logic [31:0] d, input logic r);
    logic       e_rdy, e_ov;
    logic [3:0] e_en;
    in_valid = v; in_data = d; out_ready = r;
    #2;
    e_rdy = (m_mode == 1) ? r : 1'b1;
    e_ov  = (m_mode == 1) && v;
    for (int i = 0; i < 4; i++) e_en[i] = e_ov && (m_rem > i);
    chk(cur_req, "in_ready", 32'(in_ready), 32'(e_rdy));
    chk(cur_req, "out_valid", 32'(out_valid), 32'(e_ov));
    chk(cur_req, "out_byte_en", 32'(out_byte_en), 32'(e_en));
    if (e_ov) chk(cur_req, "out_data", out_data, d);
    chk(cur_req, "pkt_dtype", 32'(pkt_dtype), 32'(m_dt));
    chk(cur_req, "pkt_vc", 32'(pkt_vc), 32'(m_vc));
    chk(cur_req, "pkt_len", 32'(pkt_len), 32'(m_len));
    if (!v) begin
      m_mode = 0;
    end else if (m_mode == 0) begin
      if (d[5:0] >= 6'h10 && d[5:0] == 6'h2B) begin
        m_dt = d[5:0]; m_vc = d[7:6]; m_len = d[23:8];
        m_rem = int'(d[23:8]);
        m_mode = (m_rem == 0) ? 2 : 1;
      end else begin
        m_mode = 2;
      end
    end else if (m_mode == 1 && r) begin
      m_rem = (m_rem > 4) ? m_rem - 4 : 0;
      if (m_rem == 0) m_mode = 2;
    end
    @(posedge clk);
    #1;
  endtask

  // header with out_ready low, nw following words, optional stalls, then burst end
  task automatic burst(input logic [31:0] hdr, input int nw, input int stall_mask,
                       input int seed);
    logic [31:0] w;
    step(1'b1, hdr, 1'b0);
    for (int j = 0; j < nw; j++) begin
      w = {8'(seed), 8'(j), 8'hC3, 8'(j * 7 + seed)};
      if (stall_mask[j]) step(1'b1, w, 1'b0);
      step(1'b1, w, 1'b1);
    end
    step(1'b0, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset values
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "out_byte_en", 32'(out_byte_en), 32'd0);
    chk("R1", "pkt_len", 32'(pkt_len), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cur_req = "R1"; step(1'b0, 32'h0, 1'b0);

    // R2 R5 R7: wc=8, two payload words, checksum word, filler
    cur_req = "R5"; burst(mk_hdr(2'd0, 6'h2B, 16'd8), 4, 0, 1);
    // R6: wc=5, checksum shares the last payload word
    cur_req = "R6"; burst(mk_hdr(2'd1, 6'h2B, 16'd5), 3, 0, 2);
    // R9: wc=7 with stalls on a middle and on the final payload word
    cur_req = "R9"; burst(mk_hdr(2'd0, 6'h2B, 16'd7), 3, 32'b011, 3);
    // R3: other long data type, side outputs unchanged
    cur_req = "R3"; burst(mk_hdr(2'd3, 6'h2A, 16'd8), 4, 0, 4);
    // R4: short packet whose bytes 1-2 look like a length
    cur_req = "R4"; burst(mk_hdr(2'd0, 6'h00, 16'd12), 4, 0, 5);
    cur_req = "R4"; burst(mk_hdr(2'd2, 6'h0B, 16'd4), 2, 0, 6);
    // R7: virtual channel and length captured
    cur_req = "R7"; burst(mk_hdr(2'd2, 6'h2B, 16'd12), 5, 32'b100, 7);
    // R8: burst ends mid payload, next burst decodes a new header
    cur_req = "R8"; burst(mk_hdr(2'd0, 6'h2B, 16'd40), 2, 0, 8);
    cur_req = "R8"; burst(mk_hdr(2'd1, 6'h2B, 16'd3), 2, 0, 9);
    // R10: zero-length matching long packet
    cur_req = "R10"; burst(mk_hdr(2'd3, 6'h2B, 16'd0), 3, 0, 10);
    // R2: back-to-back bursts, header held against out_ready low
    cur_req = "R2"; burst(mk_hdr(2'd0, 6'h2B, 16'd4), 2, 32'b1, 11);
    cur_req = "R2"; burst(mk_hdr(2'd1, 6'h2B, 16'd1), 2, 0, 12);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule